// File: doc/BRIEF.md
# Clocked Register Access Port with Split-Latency Counter Reads

This block is a synchronous slave port through which a host reads and writes a bank of 16-bit registers using an 8-bit address. The host pulls an active-low select low and, on the same rising clock edge, presents an address and one of two active-low strobes, one for read and one for write. Write data is taken on that edge. Read data comes back on a dedicated 16-bit output bus together with a valid flag. The separate input and output data buses stand in for a shared bidirectional pad.

Besides the plain control registers, the port reaches a set of 32-bit statistics counters. Each counter is fetched as two 16-bit halves, and these halves take longer to return. Reading the low half also freezes the counter's high half in a per-counter holding latch, so that a later high-half read gives a value that matches the earlier low half. While a counter fetch is outstanding, the port raises a busy output and drops any access the host offers. The counters advance on per-counter increment inputs. A write to either half presets it.

The select may be held low across many cycles, so that ordinary accesses run back to back, one per clock. If both strobes are low on the same edge, the port treats the access as an error and raises a one-cycle error flag.

Top module: `regPort`

## Requirements
- R1: After reset, rdData, rdValid, busy and accessErr are 0. Every ordinary register, every counter and every high-half latch holds 0.
- R2: When csN=0, wrN=0 and rdN=1 on a rising edge with busy low, wrData is stored into the ordinary register at the sampled address, provided that address lies in 0x00–0x0F.
- R3: When csN=0, rdN=0 and wrN=1 on a rising edge with busy low, the word for any non-counter address appears on rdData with rdValid=1 for the one cycle after that edge. Addresses 0x00–0x0F return the stored register. Every other non-counter address (0x10–0x3F, 0x50–0xFF) reads as 0, and writes to those addresses change nothing.
- R4: rdData is 0 in every cycle in which rdValid is 0.
- R5: With csN held low over consecutive edges, each edge is a separate access, and consecutive ordinary reads return valid data in consecutive cycles.
- R6: Counter i (0..7) has its low half at address 0x40+2i and its high half at 0x41+2i. A write to either address loads that 16-bit half of the counter.
- R7: A low-half read returns counter bits 15:0, as they stood at the sampling edge, after six clocks. rdValid is high in the cycle after the fifth edge following the sampling edge. The same read copies counter bits 31:16 into that counter's high-half latch.
- R8: A high-half read returns the counter's high-half latch after three clocks. rdValid is high in the cycle after the second edge following the sampling edge.
- R9: busy is high from the cycle after a counter read is accepted until its data cycle, and is low in the data cycle. Any access sampled while busy is high is ignored.
- R10: When csN=0, rdN=0 and wrN=0 on an edge with busy low, no register changes and no read data is returned. accessErr is 1 for the one following cycle.
- R11: While cntInc[i]=1, counter i increases by one on each edge, wrapping modulo 2^32. A write to one of its halves on the same edge takes precedence over the increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low port select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| addr | input | 8 | Register address |
| wrData | input | 16 | Write data, taken on the sampling edge |
| cntInc | input | 8 | Per-counter increment enables |
| rdData | output | 16 | Read data, zero when not valid |
| rdValid | output | 1 | Marks the cycle holding read data |
| busy | output | 1 | Counter fetch outstanding; accesses dropped |
| accessErr | output | 1 | One-cycle pulse after a dual-strobe access |

## Verification
A table of writes and reads covers ordinary registers at both ends of the bank, unmapped addresses in the gaps below and above the counter window, and both halves of the first and last counters. This separates correct address decoding and half selection from reads that merely return stale data. Each read is checked cycle by cycle up to its data cycle, so a latency that is one cycle short or long shows up as early or missing valid data, and not as a wrong value.

Directed sequences then cover the following cases:
- reads issued back to back under one select;
- a dual-strobe access;
- a write offered while busy;
- increments that land between a low-half read and a high-half read, which separate a live high half from a latched one;
- a 32-bit wrap;
- a write and an increment on the same edge.

// File: rtl/regPortPkg.sv
package regPortPkg;

  typedef enum logic [1:0] {
    KIND_REG   = 2'd0,
    KIND_CNTLO = 2'd1,
    KIND_CNTHI = 2'd2,
    KIND_NONE  = 2'd3
  } accKind_t;

  // strobes from control to datapath, valid for the current edge
  typedef struct packed {
    logic regWe;   // ordinary register write
    logic cntWe;   // counter half preset
    logic ordRd;   // non-counter read, answered next cycle
    logic cntRd;   // counter half read accepted, fetch into hold word
    logic emit;    // pending counter word goes out on this edge
  } ctrlStrb_t;

  function automatic accKind_t classify(input int a, input int numRegs,
                                        input int cntBase, input int numCnt);
    if (a < numRegs)
      return KIND_REG;
    else if (a >= cntBase && a < cntBase + 2 * numCnt)
      return ((a - cntBase) % 2 == 0) ? KIND_CNTLO : KIND_CNTHI;
    else
      return KIND_NONE;
  endfunction

endpackage

// File: rtl/regPortCtrl.sv
module regPortCtrl
  import regPortPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int CNT_BASE = 64,
  parameter int NUM_CNT  = 8,
  parameter int LO_LAT   = 6,
  parameter int HI_LAT   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  output ctrlStrb_t         strb,
  output logic              busy,
  output logic              accessErr
);

  localparam int MAX_LAT = (LO_LAT > HI_LAT) ? LO_LAT : HI_LAT;
  localparam int WAIT_W  = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;

  logic [WAIT_W-1:0] waitCnt;
  logic              sel, rdReq, wrReq, clash, isCnt;
  accKind_t          kind;

  assign kind  = classify(int'(addr), NUM_REGS, CNT_BASE, NUM_CNT);
  assign isCnt = (kind == KIND_CNTLO) || (kind == KIND_CNTHI);
  assign busy  = (waitCnt != '0);

  // an access is only seen when selected and nothing is outstanding
  assign sel   = !csN && !busy;
  assign rdReq = sel && !rdN &&  wrN;
  assign wrReq = sel &&  rdN && !wrN;
  assign clash = sel && !rdN && !wrN;

  always_comb begin
    strb.regWe = wrReq && (kind == KIND_REG);
    strb.cntWe = wrReq && isCnt;
    strb.ordRd = rdReq && !isCnt;
    strb.cntRd = rdReq && isCnt;
    strb.emit  = (waitCnt == WAIT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt   <= '0;
      accessErr <= 1'b0;
    end else begin
      accessErr <= clash;
      if (strb.cntRd)
        waitCnt <= (kind == KIND_CNTLO) ? WAIT_W'(LO_LAT - 1) : WAIT_W'(HI_LAT - 1);
      else if (busy)
        waitCnt <= waitCnt - WAIT_W'(1);
    end
  end

  // R7: the countdown never exceeds the longest fetch
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    int'(waitCnt) <= MAX_LAT - 1);

  // R9: busy persists until the emitting edge
  p_busy_run_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.emit) |=> busy);

  initial begin
    assert (LO_LAT >= 2 && HI_LAT >= 2)
      else $display("regPortCtrl: counter latencies must be at least 2");
  end

endmodule

// File: rtl/regPortData.sv
module regPortData
  import regPortPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int CNT_BASE = 64,
  parameter int NUM_CNT  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_CNT-1:0] cntInc,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  localparam int REG_IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CNT_IDX_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;
  localparam int CNT_W     = 2 * DATA_W;

  logic [DATA_W-1:0]    regView [NUM_REGS];
  logic [CNT_W-1:0]     cntView [NUM_CNT];
  logic [DATA_W-1:0]    hiView  [NUM_CNT];
  logic [DATA_W-1:0]    heldWord;
  logic [ADDR_W-1:0]    cntOff;
  logic [CNT_IDX_W-1:0] cntIdx;
  logic                 cntHi;
  logic [REG_IDX_W-1:0] regIdx;
  accKind_t             kind;

  assign kind   = classify(int'(addr), NUM_REGS, CNT_BASE, NUM_CNT);
  assign regIdx = REG_IDX_W'(addr);
  assign cntOff = addr - ADDR_W'(CNT_BASE);
  assign cntIdx = CNT_IDX_W'(cntOff >> 1);
  assign cntHi  = cntOff[0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [DATA_W-1:0] regVal;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regVal <= '0;
      else if (strb.regWe && regIdx == REG_IDX_W'(g))
        regVal <= wrData;
    end
    assign regView[g] = regVal;
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    logic [CNT_W-1:0]  cntVal;
    logic [DATA_W-1:0] hiHold;
    logic              hitMe;
    assign hitMe = (cntIdx == CNT_IDX_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntVal <= '0;
        hiHold <= '0;
      end else begin
        if (strb.cntWe && hitMe) begin
          if (cntHi) cntVal[CNT_W-1:DATA_W] <= wrData;
          else       cntVal[DATA_W-1:0]     <= wrData;
        end else if (cntInc[g]) begin
          cntVal <= cntVal + CNT_W'(1);
        end
        if (strb.cntRd && hitMe && !cntHi)
          hiHold <= cntVal[CNT_W-1:DATA_W];
      end
    end
    assign cntView[g] = cntVal;
    assign hiView[g]  = hiHold;
  end

  // word fetched at acceptance, held until the emitting edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      heldWord <= '0;
    else if (strb.cntRd)
      heldWord <= cntHi ? hiView[cntIdx] : cntView[cntIdx][DATA_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (strb.ordRd) begin
      rdData  <= (kind == KIND_REG) ? regView[regIdx] : '0;
      rdValid <= 1'b1;
    end else if (strb.emit) begin
      rdData  <= heldWord;
      rdValid <= 1'b1;
    end else begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end
  end

  // R4: idle output bus is zero
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  // R2: a register write is visible at the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.regWe |=> (regView[$past(regIdx)] == $past(wrData)));

endmodule

// File: rtl/regPort.sv
module regPort
  import regPortPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 16,
  parameter int CNT_BASE = 64,
  parameter int NUM_CNT  = 8,
  parameter int LO_LAT   = 6,
  parameter int HI_LAT   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               rdN,
  input  logic               wrN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_CNT-1:0] cntInc,
  output logic [DATA_W-1:0]  rdData,
  output logic               rdValid,
  output logic               busy,
  output logic               accessErr
);

  ctrlStrb_t strb;

  regPortCtrl #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .CNT_BASE(CNT_BASE),
    .NUM_CNT(NUM_CNT), .LO_LAT(LO_LAT), .HI_LAT(HI_LAT)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .strb(strb), .busy(busy), .accessErr(accessErr)
  );

  regPortData #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .CNT_BASE(CNT_BASE), .NUM_CNT(NUM_CNT)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .cntInc(cntInc), .rdData(rdData), .rdValid(rdValid)
  );

  // R9: the cycle busy drops is the data cycle
  p_fell_busy_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> rdValid);

  // R9: no read data while a fetch is outstanding
  p_busy_no_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !rdValid);

  // R10: an error cycle carries no read data
  p_err_no_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> !rdValid);

  // R7: accepting a counter read raises busy
  p_cnt_read_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntRd |=> busy);

endmodule

// File: tb/test_regPort.sv
module test_regPort;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [7:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [7:0]  cntInc = '0;
  logic [15:0] rdData;
  logic        rdValid, busy, accessErr;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regPort i_regPort (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .wrData(wrData), .cntInc(cntInc), .rdData(rdData), .rdValid(rdValid),
    .busy(busy), .accessErr(accessErr)
  );

  typedef struct packed {
    logic        isRd;
    logic [7:0]  a;
    logic [15:0] d;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 16'hA5A5}, '{1'b0, 8'h0F, 16'h1234}, '{1'b0, 8'h07, 16'hFFFF},
    '{1'b1, 8'h00, 16'hA5A5}, '{1'b1, 8'h0F, 16'h1234}, '{1'b1, 8'h07, 16'hFFFF},
    '{1'b1, 8'h03, 16'h0000}, '{1'b0, 8'h10, 16'hBEEF}, '{1'b1, 8'h10, 16'h0000},
    '{1'b0, 8'h3F, 16'h5555}, '{1'b1, 8'h3F, 16'h0000}, '{1'b1, 8'hFF, 16'h0000},
    '{1'b0, 8'h40, 16'h1111}, '{1'b0, 8'h41, 16'h2222}, '{1'b1, 8'h41, 16'h0000},
    '{1'b1, 8'h40, 16'h1111}, '{1'b1, 8'h41, 16'h2222}, '{1'b0, 8'h4F, 16'h9ABC},
    '{1'b0, 8'h4E, 16'h0DEF}, '{1'b1, 8'h4E, 16'h0DEF}, '{1'b1, 8'h4F, 16'h9ABC},
    '{1'b0, 8'h50, 16'h7777}, '{1'b1, 8'h50, 16'h0000}, '{1'b1, 8'h00, 16'hA5A5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int latOf(input logic [7:0] a);
    if (a >= 8'h40 && a <= 8'h4F) return a[0] ? 3 : 6;
    return 1;
  endfunction

  function automatic string tagOf(input logic [7:0] a);
    if (a >= 8'h40 && a <= 8'h4F) return a[0] ? "R8" : "R7";
    return "R3";
  endfunction

  // called at a negedge; returns at a negedge
  task automatic wrAcc(input logic [7:0] a, input logic [15:0] d);
    csN = 1'b0; wrN = 1'b0; rdN = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
  endtask

  task automatic rdAcc(input logic [7:0] a, input logic [15:0] exp, input string tag);
    int lat;
    lat = latOf(a);
    csN = 1'b0; rdN = 1'b0; wrN = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    csN = 1'b1; rdN = 1'b1;
    for (int i = 1; i <= lat; i++) begin
      if (i < lat) begin
        chk({tag, " wait valid"}, {31'd0, rdValid}, 32'd0);
        chk({tag, " wait data R4"}, {16'd0, rdData}, 32'd0);
        chk({tag, " busy R9"}, {31'd0, busy}, 32'd1);
        @(negedge clk);
      end else begin
        chk({tag, " valid"}, {31'd0, rdValid}, 32'd1);
        chk({tag, " data"}, {16'd0, rdData}, {16'd0, exp});
        chk({tag, " busy low R9"}, {31'd0, busy}, 32'd0);
      end
    end
  endtask

  task automatic pulseInc(input int idx, input int n);
    cntInc[idx] = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    cntInc = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rdValid", {31'd0, rdValid}, 32'd0);
    chk("R1 rdData", {16'd0, rdData}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 accessErr", {31'd0, accessErr}, 32'd0);
    rdAcc(8'h05, 16'h0000, "R1 reg");
    @(negedge clk);
    rdAcc(8'h46, 16'h0000, "R1 cnt");
    @(negedge clk);

    // vector table: R2, R3, R6, R7, R8
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].isRd) rdAcc(VECS[v].a, VECS[v].d, tagOf(VECS[v].a));
      else              wrAcc(VECS[v].a, VECS[v].d);
      @(negedge clk);
    end

    // R5 back to back under one select
    csN = 1'b0; rdN = 1'b0; addr = 8'h0F;
    @(posedge clk); @(negedge clk);
    chk("R5 first valid", {31'd0, rdValid}, 32'd1);
    chk("R5 first data", {16'd0, rdData}, 32'h1234);
    addr = 8'h00;
    @(posedge clk); @(negedge clk);
    chk("R5 second valid", {31'd0, rdValid}, 32'd1);
    chk("R5 second data", {16'd0, rdData}, 32'hA5A5);
    csN = 1'b1; rdN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R4 idle valid", {31'd0, rdValid}, 32'd0);
    chk("R4 idle data", {16'd0, rdData}, 32'd0);

    // R10 dual strobe
    csN = 1'b0; rdN = 1'b0; wrN = 1'b0; addr = 8'h00; wrData = 16'h0000;
    @(posedge clk); @(negedge clk);
    csN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    chk("R10 err pulse", {31'd0, accessErr}, 32'd1);
    chk("R10 no valid", {31'd0, rdValid}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R10 err clears", {31'd0, accessErr}, 32'd0);
    rdAcc(8'h00, 16'hA5A5, "R10 reg unchanged");
    @(negedge clk);

    // R9 write offered while busy is dropped
    csN = 1'b0; rdN = 1'b0; addr = 8'h40;
    @(posedge clk); @(negedge clk);
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    rdN = 1'b1; wrN = 1'b0; addr = 8'h03; wrData = 16'hDEAD;
    @(posedge clk); @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
    for (int i = 2; i <= 6; i++) begin
      if (i < 6) begin
        chk("R9 busy held", {31'd0, busy}, 32'd1);
        @(negedge clk);
      end else begin
        chk("R9 data valid", {31'd0, rdValid}, 32'd1);
        chk("R9 data", {16'd0, rdData}, 32'h1111);
      end
    end
    @(negedge clk);
    rdAcc(8'h03, 16'h0000, "R9 dropped write");
    @(negedge clk);

    // R11 increments, high-half latch R8
    wrAcc(8'h44, 16'hFFFF); @(negedge clk);
    wrAcc(8'h45, 16'h0001); @(negedge clk);
    pulseInc(2, 1);
    rdAcc(8'h44, 16'h0000, "R11 carry lo"); @(negedge clk);
    rdAcc(8'h45, 16'h0002, "R11 carry hi"); @(negedge clk);
    pulseInc(2, 3);
    rdAcc(8'h45, 16'h0002, "R8 latched hi"); @(negedge clk);
    rdAcc(8'h44, 16'h0003, "R11 lo count"); @(negedge clk);
    rdAcc(8'h45, 16'h0002, "R8 hi relatch"); @(negedge clk);

    // R11 wrap
    wrAcc(8'h46, 16'hFFFF); @(negedge clk);
    wrAcc(8'h47, 16'hFFFF); @(negedge clk);
    pulseInc(3, 1);
    rdAcc(8'h46, 16'h0000, "R11 wrap lo"); @(negedge clk);
    rdAcc(8'h47, 16'h0000, "R11 wrap hi"); @(negedge clk);

    // R11 write beats increment
    cntInc[4] = 1'b1;
    wrAcc(8'h48, 16'h0010);
    cntInc = '0;
    @(negedge clk);
    rdAcc(8'h48, 16'h0010, "R11 write wins"); @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule